// File: doc/BRIEF.md
# Programmable Per-Line Edge Detector Bank

This block watches a wide vector of single-bit signals and flags, one line at a time, the clock cycles in which a chosen transition happens on that line. Each line has its own 2-bit edge mode (rising, falling, either direction, or off). Each line also has its own permission bit, and one global enable gates the whole bank. The block samples the lines into a register and compares each fresh sample with the one before it. It decodes each line's mode and permission, and then registers the resulting per-line event vector together with an any-event flag.

Software sets the block up through a plain 32-bit word write/read port with a 5-bit word address. Address 0 holds the control word, and its bit 0 is the global enable. Addresses 8 to 15 hold the mask words. Addresses 16 to 31 hold the mode words. Addresses 1 to 7 are unmapped. Reads are combinational from the address. Writes take effect at the clock edge where the write enable is high.

Top module: `line_edge_watch`

## Requirements
- R1: After reset every configuration word reads 0, and events_out and any_event are 0.
- R2: Reading address 0, any address 8..15 or any address 16..31 returns exactly the last 32-bit value written there. Bit 0 of the word at address 0 is the global enable.
- R3: The mode of line n is bits [2*(n%16)+1 : 2*(n%16)] of the mode word at address 16 + n/16.
- R4: Mode code 0 reports a rising edge (previous sample 0, current 1). Code 1 reports a falling edge. Code 2 reports a change in either direction.
- R5: Mode code 3 never produces an event on its line.
- R6: The mask bit of line n is bit n%32 of the word at address 8 + n/32. A line whose mask bit is 0 never reports an event.
- R7: While the enable bit is 0, events_out stays 0. Setting the enable while the lines are steady produces no event.
- R8: A change on lines_in that is present at clock edge k shows on events_out after edge k+1. If the lines then stay steady, it lasts exactly one cycle.
- R9: any_event is 1 exactly when events_out is nonzero.
- R10: Writes to addresses 1..7 change no register, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Word address for the write and the read |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| lines_in | input | 256 | Monitored single-bit signals |
| events_out | output | 256 | Registered per-line event flags |
| any_event | output | 1 | OR of events_out |

## Verification
The bound checker enforces four rules on every cycle:
- an event only comes from a line whose sample actually changed;
- a line whose mask bit was clear stays silent;
- a disabled bank reports nothing;
- any_event can only rise after a cycle in which the bank was enabled.

Several properties can only be shown by the bench's sweeps against its arithmetic model:
- the exact per-line mapping of mode fields and mask bits;
- the meaning of each mode code, including the inert code 3;
- the two-edge latency and the one-cycle pulse width;
- register readback;
- the absence of an event when the bank is switched on.

// File: rtl/edge_bank_pkg.sv
package edge_bank_pkg;
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_OFF  = 2'd3
   } edge_mode_e;
endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs #(
   parameter int NUM_LINES = 256,
   parameter int DATA_W    = 32,
   parameter int MODE_W    = 2,
   parameter int ADDR_W    = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   output logic                        enable,
   output logic [NUM_LINES*MODE_W-1:0] mode_flat,
   output logic [NUM_LINES-1:0]        mask_flat
);
   localparam int MODE_WORDS = NUM_LINES * MODE_W / DATA_W;
   localparam int MASK_WORDS = NUM_LINES / DATA_W;
   localparam int MODE_BASE  = MODE_WORDS;
   localparam int MASK_BASE  = MASK_WORDS;

   logic [DATA_W-1:0] ctl_q;
   logic [DATA_W-1:0] mode_q [MODE_WORDS];
   logic [DATA_W-1:0] mask_q [MASK_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         for (int i = 0; i < MODE_WORDS; i++) mode_q[i] <= '0;
         for (int i = 0; i < MASK_WORDS; i++) mask_q[i] <= '0;
      end else if (we) begin
         if (addr == '0) ctl_q <= wdata;
         for (int i = 0; i < MODE_WORDS; i++)
            if (addr == ADDR_W'(MODE_BASE + i)) mode_q[i] <= wdata;
         for (int i = 0; i < MASK_WORDS; i++)
            if (addr == ADDR_W'(MASK_BASE + i)) mask_q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == '0) rdata = ctl_q;
      for (int i = 0; i < MODE_WORDS; i++)
         if (addr == ADDR_W'(MODE_BASE + i)) rdata = mode_q[i];
      for (int i = 0; i < MASK_WORDS; i++)
         if (addr == ADDR_W'(MASK_BASE + i)) rdata = mask_q[i];
   end

   assign enable = ctl_q[0];

   for (genvar w = 0; w < MODE_WORDS; w++) begin : g_mode_flat
      assign mode_flat[w*DATA_W +: DATA_W] = mode_q[w];
   end
   for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask_flat
      assign mask_flat[w*DATA_W +: DATA_W] = mask_q[w];
   end
endmodule

// File: rtl/edge_line_cell.sv
module edge_line_cell
   import edge_bank_pkg::*;
(
   input  logic       cur,
   input  logic       prev,
   input  logic [1:0] mode,
   input  logic       allow,
   output logic       hit
);
   logic det;

   always_comb begin
      case (edge_mode_e'(mode))
         EDGE_RISE: det = cur & ~prev;
         EDGE_FALL: det = ~cur & prev;
         EDGE_BOTH: det = cur ^ prev;
         default:   det = 1'b0;
      endcase
   end

   assign hit = allow & det;
endmodule

// File: rtl/line_edge_watch.sv
module line_edge_watch #(
   parameter int NUM_LINES = 256,
   parameter int DATA_W    = 32,
   parameter int MODE_W    = 2,
   parameter int ADDR_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic [DATA_W-1:0]    cfg_rdata,
   input  logic [NUM_LINES-1:0] lines_in,
   output logic [NUM_LINES-1:0] events_out,
   output logic                 any_event
);
   localparam int MODE_WORDS = NUM_LINES * MODE_W / DATA_W;

   if (MODE_W != 2) begin : g_bad_mode
      $error("line_edge_watch: MODE_W must be 2");
   end
   if (NUM_LINES % DATA_W != 0) begin : g_bad_lines
      $error("line_edge_watch: NUM_LINES must be a multiple of DATA_W");
   end
   if ((1 << ADDR_W) != 2 * MODE_WORDS) begin : g_bad_addr
      $error("line_edge_watch: ADDR_W does not fit the register map");
   end

   logic                        en_w;
   logic [NUM_LINES*MODE_W-1:0] mode_w;
   logic [NUM_LINES-1:0]        mask_w;
   logic [NUM_LINES-1:0]        sample_q;
   logic [NUM_LINES-1:0]        prev_q;
   logic [NUM_LINES-1:0]        hit_w;
   logic [NUM_LINES-1:0]        events_q;

   edge_cfg_regs #(
      .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .MODE_W(MODE_W), .ADDR_W(ADDR_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .enable(en_w),
      .mode_flat(mode_w), .mask_flat(mask_w)
   );

   // prev_q always follows sample_q, so turning the bank on sees no stale edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_q <= '0;
         prev_q   <= '0;
         events_q <= '0;
      end else begin
         sample_q <= lines_in;
         prev_q   <= sample_q;
         events_q <= hit_w;
      end
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_cell
      edge_line_cell i_cell (
         .cur(sample_q[n]), .prev(prev_q[n]),
         .mode(mode_w[n*MODE_W +: MODE_W]),
         .allow(en_w & mask_w[n]), .hit(hit_w[n])
      );
   end

   assign events_out = events_q;
   assign any_event  = |events_q;
endmodule

// File: rtl/edge_watch_chk.sv
module edge_watch_chk #(
   parameter int NUM_LINES = 256
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 en_w,
   input logic [NUM_LINES-1:0] mask_w,
   input logic [NUM_LINES-1:0] sample_q,
   input logic [NUM_LINES-1:0] prev_q,
   input logic [NUM_LINES-1:0] events_out,
   input logic                 any_event
);
   p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_w |=> (events_out == '0));

   p_masked_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((events_out & ~$past(mask_w)) == '0));

   p_event_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((events_out & ~$past(sample_q ^ prev_q)) == '0));

   p_any_after_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_event) |-> $past(en_w));
endmodule

bind line_edge_watch edge_watch_chk #(.NUM_LINES(NUM_LINES)) i_chk (
   .clk(clk), .rst_n(rst_n), .en_w(en_w), .mask_w(mask_w),
   .sample_q(sample_q), .prev_q(prev_q), .events_out(events_out),
   .any_event(any_event)
);

// File: tb/test_line_edge_watch.sv
module test_line_edge_watch;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 256;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [4:0]     cfg_addr = '0;
   logic [31:0]    cfg_wdata = '0;
   logic [31:0]    cfg_rdata;
   logic [NL-1:0]  lines_in = '0;
   logic [NL-1:0]  events_out;
   logic           any_event;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0]   bm_ctl;
   logic [31:0]   bm_mode [16];
   logic [31:0]   bm_mask [8];
   logic [NL-1:0] b_prev;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_edge_watch i_line_edge_watch (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lines_in(lines_in),
      .events_out(events_out), .any_event(any_event)
   );

   task automatic chk_vec(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_word(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 5'd0) bm_ctl = d;
      else if (a >= 5'd8 && a < 5'd16) bm_mask[a-8] = d;
      else if (a >= 5'd16) bm_mode[a-16] = d;
   endtask

   task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
      cfg_addr = a;
      #1;
      chk_word(tag, cfg_rdata, exp);
   endtask

   function automatic logic [NL-1:0] model(logic [NL-1:0] p, logic [NL-1:0] c);
      logic [NL-1:0] r;
      r = '0;
      for (int n = 0; n < NL; n++) begin
         logic [1:0] m;
         logic e;
         m = bm_mode[n/16][2*(n%16) +: 2];
         case (m)
            2'd0: e = c[n] & ~p[n];
            2'd1: e = ~c[n] & p[n];
            2'd2: e = c[n] ^ p[n];
            default: e = 1'b0;
         endcase
         r[n] = bm_ctl[0] & bm_mask[n/32][n%32] & e;
      end
      return r;
   endfunction

   function automatic logic [NL-1:0] pat(int s);
      logic [NL-1:0] v;
      for (int n = 0; n < NL; n++) v[n] = ((n * (2*s + 1) + 3*s) % 7) < 3;
      return v;
   endfunction

   task automatic apply(string tag, logic [NL-1:0] v);
      logic [NL-1:0] exp;
      exp = model(b_prev, v);
      @(negedge clk);
      lines_in = v;
      @(negedge clk);
      chk_vec({tag, " R8 not before second edge"}, events_out, '0);
      @(negedge clk);
      chk_vec(tag, events_out, exp);
      chk_word({tag, " R9 any_event"}, {31'd0, any_event}, {31'd0, |exp});
      @(negedge clk);
      chk_vec({tag, " R8 one-cycle pulse"}, events_out, '0);
      b_prev = v;
   endtask

   task automatic fill_modes(logic [31:0] w);
      for (int i = 0; i < 16; i++) wr(5'(16 + i), w);
   endtask

   task automatic fill_masks(logic [31:0] w);
      for (int i = 0; i < 8; i++) wr(5'(8 + i), w);
   endtask

   initial begin
      bm_ctl = '0;
      for (int i = 0; i < 16; i++) bm_mode[i] = '0;
      for (int i = 0; i < 8; i++) bm_mask[i] = '0;
      b_prev = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_vec("R1 events after reset", events_out, '0);
      chk_word("R1 any_event after reset", {31'd0, any_event}, 32'd0);
      rd_chk("R1 control word", 5'd0, 32'd0);
      for (int a = 8; a < 32; a++) rd_chk("R1 config word", 5'(a), 32'd0);

      // R2 readback of every mapped word
      wr(5'd0, 32'hC0DE_0000);
      for (int a = 8; a < 32; a++) wr(5'(a), 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101));
      rd_chk("R2 control readback", 5'd0, 32'hC0DE_0000);
      for (int a = 8; a < 32; a++)
         rd_chk("R2 word readback", 5'(a), 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101));

      // R10 unmapped addresses
      for (int a = 1; a < 8; a++) begin
         @(negedge clk);
         cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 32'hFFFF_FFFF;
         @(negedge clk);
         cfg_we = 1'b0;
         rd_chk("R10 unmapped reads zero", 5'(a), 32'd0);
      end
      rd_chk("R10 control untouched", 5'd0, 32'hC0DE_0000);
      for (int a = 8; a < 32; a++)
         rd_chk("R10 word untouched", 5'(a), 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101));

      // R7 disabled bank stays quiet
      wr(5'd0, 32'd0);
      fill_masks(32'hFFFF_FFFF);
      fill_modes(32'hAAAA_AAAA);
      apply("R7 disabled rise", {NL{1'b1}});
      apply("R7 disabled pattern", pat(2));
      // R7 enable while lines steady
      wr(5'd0, 32'd1);
      repeat (3) begin
         @(negedge clk);
         chk_vec("R7 no event on enable", events_out, '0);
      end
      apply("R4 toggle after enable", pat(9));

      // R4 R5 uniform mode sweep
      for (int m = 0; m < 4; m++) begin
         logic [31:0] w;
         w = {16{2'(m)}};
         fill_modes(w);
         apply(m == 3 ? "R5 code 3 ones" : "R4 all ones", {NL{1'b1}});
         apply(m == 3 ? "R5 code 3 zeros" : "R4 all zeros", '0);
         apply(m == 3 ? "R5 code 3 pattern" : "R4 pattern a", pat(5));
         apply(m == 3 ? "R5 code 3 pattern" : "R4 pattern b", pat(11));
      end

      // R3 R6 per-line modes and masks
      for (int i = 0; i < 16; i++) begin
         logic [31:0] w;
         for (int f = 0; f < 16; f++) w[2*f +: 2] = 2'((3*(16*i + f) + i) % 4);
         wr(5'(16 + i), w);
      end
      for (int k = 0; k < 8; k++) wr(5'(8 + k), 32'h9E37_79B9 ^ (32'(k) * 32'h0F0F_1111));
      for (int s = 1; s <= 12; s++) apply("R3 R6 mixed lines", pat(s));

      // R6 full mask off
      fill_modes(32'hAAAA_AAAA);
      fill_masks(32'd0);
      apply("R6 masked toggle", ~b_prev);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule